// File: doc/BRIEF.md
# PLL and Clock-Divider Control Unit

This unit holds the settings that a phase-locked loop and three system-clock dividers consume. It turns the divider settings into one-cycle clock-enable strobes for a tile domain, a switch domain and a reference domain. The analog loop itself is not part of the block. It is represented only by three output fields:

- an input pre-divider `R`, which divides by R+1;
- a feedback multiplier `F`, which multiplies by (F+1)/2;
- an output post-divider `OD`, which divides by OD+1.

After power-on, the loop word is loaded from two mode pins, which are sampled while the power-on reset is held. A later software write to the loop word keeps the new value. The same write raises a self-reset request for a fixed number of system clocks. During that window the divider settings return to their defaults, and the loop word survives.

The three divider settings can be rewritten at any time without any reset. A new ratio is adopted only when the running count reaches its terminal value, so no period is ever cut short. The tile path can bypass its divider, and its enable then fires on every system clock. Software reaches all of this through a plain register port: a write strobe, a register number, 32-bit write data and a combinational read-data output.

Top module: `clkctl_unit`

## Requirements
- R1: While `por_n` is low the loop word is loaded from `mode_pins`:
  - 2'b11 gives R=0, F=119, OD=2.
  - 2'b10 gives R=0, F=49, OD=2.
  - 2'b01 gives R=0, F=23, OD=2.
  - 2'b00 gives R=0, F=122, OD=1.
  
  Register 6 then reads the word `OD<<23 | F<<8 | R`.
- R2: The outputs decode register 6 as follows: `pll_r` is bits [6:0], `pll_f` is bits [20:8] and `pll_od` is bits [25:23]. For example, the word 0x01005F00 gives R=0, F=95, OD=2.
- R3: An accepted write to register 6 stores the full 32-bit word. `self_rst_req` is high from the next cycle for exactly 8 system clocks, and register 6 then reads back the written word.
- R4: The self-reset does not reload the loop word from `mode_pins`, even when the pins have changed. Only `por_n` low reloads it.
- R5: The switch divider is register 7, bits [15:0], with a power-on value of 0. `sw_en` pulses once every N+1 clocks; a value of 399 gives a period of 400.
- R6: The reference divider is register 8, bits [15:0], with a power-on value of 3. This gives a `ref_en` period of 4, and writing 2 gives a period of 3.
- R7: The tile control is register 9. Bits [15:0] hold the tile divide value N, with a default of 0, and `tile_en` then pulses every N+1 clocks. Bit 16 selects bypass: it drives `tile_bypass` high, and `tile_en` is then high on every clock.
- R8: Writes to registers 7, 8 and 9 never raise `self_rst_req` and leave register 6 unchanged.
- R9: While `self_rst_req` is high, all three enables are low, and registers 7, 8 and 9 return to 0, 3 and 0.
- R10: A new divide value takes effect only at the next terminal count. The period in progress completes with the old value.
- R11: Register numbers other than 6 to 9 read as zero. Writes to them change nothing.
- R12: Writes that arrive while `self_rst_req` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| mode_pins | input | 2 | Boot mode selection for the loop word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register number |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pll_r | output | 7 | Loop pre-divider field |
| pll_f | output | 13 | Loop multiplier field |
| pll_od | output | 3 | Loop post-divider field |
| self_rst_req | output | 1 | Self-reset request after a loop-word write |
| tile_bypass | output | 1 | Tile path uses the system clock directly |
| tile_en | output | 1 | Tile-domain clock enable |
| sw_en | output | 1 | Switch-domain clock enable |
| ref_en | output | 1 | Reference-domain clock enable |

## Verification
Two situations are hard to reach from the ports. The first is a divider rewrite that lands in the middle of a running period, so that the old ratio must still close that period. The bench reaches it by first watching for a reference strobe, then issuing the rewrite on that same sampling edge. It then checks that the next gap keeps the old length and that the gap after it has the new length.

The second is a write during the self-reset window. The bench reaches it by issuing further writes to a divider and to the loop word directly after the first loop-word write. It then checks that the window still lasts eight cycles in total and that neither write was kept.

// File: rtl/clkctl_pkg.sv
`timescale 1ns/1ps
package clkctl_pkg;

    localparam int unsigned REG_PLL   = 6;
    localparam int unsigned REG_SWDIV = 7;
    localparam int unsigned REG_REFDIV = 8;
    localparam int unsigned REG_TILE  = 9;

    localparam int unsigned REF_DIV_RST = 3;
    localparam int unsigned TILE_BYP_BIT = 16;

    function automatic logic [31:0] pll_word(input logic [6:0] r,
                                             input logic [12:0] f,
                                             input logic [2:0] od);
        logic [31:0] w;
        w        = '0;
        w[6:0]   = r;
        w[20:8]  = f;
        w[25:23] = od;
        return w;
    endfunction

    function automatic logic [31:0] mode_pll_word(input logic [1:0] m);
        logic [31:0] w;
        case (m)
            2'b00:   w = pll_word(7'd0, 13'd122, 3'd1);
            2'b01:   w = pll_word(7'd0, 13'd23,  3'd2);
            2'b10:   w = pll_word(7'd0, 13'd49,  3'd2);
            default: w = pll_word(7'd0, 13'd119, 3'd2);
        endcase
        return w;
    endfunction

endpackage

// File: rtl/clkctl_regs.sv
`timescale 1ns/1ps
module clkctl_regs
    import clkctl_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DIV_W   = 16,
    parameter int RST_CYC = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [1:0]        mode_pins,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [31:0]       pll_word_o,
    output logic [DIV_W-1:0]  sw_div_o,
    output logic [DIV_W-1:0]  ref_div_o,
    output logic [DIV_W-1:0]  tile_div_o,
    output logic              tile_byp_o,
    output logic              rst_req_o
);

    localparam int CW = $clog2(RST_CYC + 1);
    localparam logic [DIV_W-1:0] REF_RST = DIV_W'(REF_DIV_RST);

    typedef struct packed {
        logic [31:0]      pll;
        logic [DIV_W-1:0] sw;
        logic [DIV_W-1:0] rf;
        logic [DIV_W-1:0] tl;
        logic             byp;
        logic [CW-1:0]    rcnt;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!por_n) begin
            st_d.pll  = mode_pll_word(mode_pins);
            st_d.sw   = '0;
            st_d.rf   = REF_RST;
            st_d.tl   = '0;
            st_d.byp  = 1'b0;
            st_d.rcnt = '0;
        end else if (st_q.rcnt != '0) begin
            st_d.rcnt = st_q.rcnt - 1'b1;
            st_d.sw   = '0;
            st_d.rf   = REF_RST;
            st_d.tl   = '0;
            st_d.byp  = 1'b0;
        end else if (wr_en) begin
            case (addr)
                ADDR_W'(REG_PLL): begin
                    st_d.pll  = wdata;
                    st_d.rcnt = CW'(RST_CYC);
                end
                ADDR_W'(REG_SWDIV):  st_d.sw = wdata[DIV_W-1:0];
                ADDR_W'(REG_REFDIV): st_d.rf = wdata[DIV_W-1:0];
                ADDR_W'(REG_TILE): begin
                    st_d.tl  = wdata[DIV_W-1:0];
                    st_d.byp = wdata[TILE_BYP_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(REG_PLL):    rdata = st_q.pll;
            ADDR_W'(REG_SWDIV):  rdata[DIV_W-1:0] = st_q.sw;
            ADDR_W'(REG_REFDIV): rdata[DIV_W-1:0] = st_q.rf;
            ADDR_W'(REG_TILE): begin
                rdata[DIV_W-1:0]    = st_q.tl;
                rdata[TILE_BYP_BIT] = st_q.byp;
            end
            default: ;
        endcase
    end

    assign pll_word_o = st_q.pll;
    assign sw_div_o   = st_q.sw;
    assign ref_div_o  = st_q.rf;
    assign tile_div_o = st_q.tl;
    assign tile_byp_o = st_q.byp;
    assign rst_req_o  = (st_q.rcnt != '0);

    // R3: an accepted loop-word write is captured and starts the request
    a_r3_pll_capture: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && addr == ADDR_W'(REG_PLL) && !rst_req_o)
        |=> (rst_req_o && pll_word_o == $past(wdata)));

    // R12: the loop word is frozen while the request is active
    a_r12_locked: assert property (@(posedge clk) disable iff (!por_n)
        rst_req_o |=> $stable(pll_word_o));

    // R8: divider writes never start a self-reset
    a_r8_div_no_reset: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !rst_req_o && addr >= ADDR_W'(REG_SWDIV) && addr <= ADDR_W'(REG_TILE))
        |=> !rst_req_o);

    // R9: divider settings return to defaults during the self-reset
    a_r9_defaults: assert property (@(posedge clk) disable iff (!por_n)
        rst_req_o |=> (sw_div_o == '0 && ref_div_o == REF_RST
                       && tile_div_o == '0 && !tile_byp_o));

endmodule

// File: rtl/clkctl_div.sv
`timescale 1ns/1ps
module clkctl_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         clr_i,
    input  logic [W-1:0] div_i,
    output logic         en_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] lim;
    } div_t;

    div_t st_d, st_q;
    logic term;

    assign term = (st_q.cnt == st_q.lim);

    always_comb begin
        st_d = st_q;
        if (clr_i || term) begin
            st_d.cnt = '0;
            st_d.lim = div_i;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign en_o = term && !clr_i;

    // R10: the limit in force does not move inside a period
    a_r10_limit_held: assert property (@(posedge clk) disable iff (clr_i)
        !en_o |=> $stable(st_q.lim));

    // R5: a non-zero divide value never gives back-to-back strobes
    a_r5_no_double: assert property (@(posedge clk) disable iff (clr_i)
        (en_o && div_i != '0) |=> !en_o);

endmodule

// File: rtl/clkctl_unit.sv
`timescale 1ns/1ps
module clkctl_unit #(
    parameter int ADDR_W  = 8,
    parameter int DIV_W   = 16,
    parameter int RST_CYC = 8
) (
    input  logic              clk_sys,
    input  logic              por_n,
    input  logic [1:0]        mode_pins,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [6:0]        pll_r,
    output logic [12:0]       pll_f,
    output logic [2:0]        pll_od,
    output logic              self_rst_req,
    output logic              tile_bypass,
    output logic              tile_en,
    output logic              sw_en,
    output logic              ref_en
);

    localparam int NDIV = 3;

    logic [31:0]      pll_q;
    logic [DIV_W-1:0] div_val [NDIV];
    logic [NDIV-1:0]  div_en;
    logic             div_clr;

    clkctl_regs #(
        .ADDR_W (ADDR_W),
        .DIV_W  (DIV_W),
        .RST_CYC(RST_CYC)
    ) u_regs (
        .clk        (clk_sys),
        .por_n      (por_n),
        .mode_pins  (mode_pins),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .pll_word_o (pll_q),
        .sw_div_o   (div_val[1]),
        .ref_div_o  (div_val[2]),
        .tile_div_o (div_val[0]),
        .tile_byp_o (tile_bypass),
        .rst_req_o  (self_rst_req)
    );

    assign div_clr = !por_n || self_rst_req;

    for (genvar i = 0; i < NDIV; i++) begin : g_div
        clkctl_div #(.W(DIV_W)) u_div (
            .clk   (clk_sys),
            .clr_i (div_clr),
            .div_i (div_val[i]),
            .en_o  (div_en[i])
        );
    end

    assign pll_r  = pll_q[6:0];
    assign pll_f  = pll_q[20:8];
    assign pll_od = pll_q[25:23];

    assign tile_en = tile_bypass ? !self_rst_req : div_en[0];
    assign sw_en   = div_en[1];
    assign ref_en  = div_en[2];

    // R9: no domain enable fires while the self-reset is requested
    a_r9_enables_quiet: assert property (@(posedge clk_sys) disable iff (!por_n)
        self_rst_req |-> !(tile_en || sw_en || ref_en));

endmodule

// File: tb/clkctl_unit_bench.sv
`timescale 1ns/1ps
module clkctl_unit_bench;

    logic        clk = 1'b0;
    logic        por_n;
    logic [1:0]  mode_pins;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [6:0]  pll_r;
    logic [12:0] pll_f;
    logic [2:0]  pll_od;
    logic        self_rst_req, tile_bypass, tile_en, sw_en, ref_en;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    clkctl_unit u_clkctl_unit (
        .clk_sys(clk), .por_n(por_n), .mode_pins(mode_pins),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pll_r(pll_r), .pll_f(pll_f), .pll_od(pll_od),
        .self_rst_req(self_rst_req), .tile_bypass(tile_bypass),
        .tile_en(tile_en), .sw_en(sw_en), .ref_en(ref_en)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [15:0] per;
        logic        byp;
    } vec_t;

    // sel: 0 tile, 1 switch, 2 reference
    localparam vec_t VECS [8] = '{
        '{sel: 2'd1, addr: 8'd7, data: 32'd3,       per: 16'd4,   byp: 1'b0},
        '{sel: 2'd1, addr: 8'd7, data: 32'd399,     per: 16'd400, byp: 1'b0},
        '{sel: 2'd1, addr: 8'd7, data: 32'd0,       per: 16'd1,   byp: 1'b0},
        '{sel: 2'd2, addr: 8'd8, data: 32'd2,       per: 16'd3,   byp: 1'b0},
        '{sel: 2'd2, addr: 8'd8, data: 32'd6,       per: 16'd7,   byp: 1'b0},
        '{sel: 2'd0, addr: 8'd9, data: 32'd4,       per: 16'd5,   byp: 1'b0},
        '{sel: 2'd0, addr: 8'd9, data: 32'h0001_0004, per: 16'd1, byp: 1'b1},
        '{sel: 2'd0, addr: 8'd9, data: 32'd1,       per: 16'd2,   byp: 1'b0}
    };

    function automatic logic [31:0] mk_word(input logic [6:0] r, input logic [12:0] f,
                                            input logic [2:0] od);
        return (32'(od) << 23) | (32'(f) << 8) | 32'(r);
    endfunction

    function automatic logic [31:0] boot_word(input logic [1:0] m);
        case (m)
            2'b00:   return mk_word(7'd0, 13'd122, 3'd1);
            2'b01:   return mk_word(7'd0, 13'd23,  3'd2);
            2'b10:   return mk_word(7'd0, 13'd49,  3'd2);
            default: return mk_word(7'd0, 13'd119, 3'd2);
        endcase
    endfunction

    function automatic logic strobe(input int s);
        if (s == 0) return tile_en;
        if (s == 1) return sw_en;
        return ref_en;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic power_on(input logic [1:0] m);
        @(negedge clk);
        por_n = 1'b0;
        mode_pins = m;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic get_period(input int s, output int p);
        int w;
        w = 0;
        while (!strobe(s) && w < 1000) begin @(negedge clk); w++; end
        @(negedge clk);
        p = 1;
        while (!strobe(s) && p < 1000) begin @(negedge clk); p++; end
    endtask

    initial begin
        #3_000_000;
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int p, c;
        por_n = 1'b0; mode_pins = 2'b11; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;

        // R1 / R2: boot word from every mode pin pattern
        for (int m = 0; m < 4; m++) begin
            power_on(2'(m));
            rd(8'd6, v);
            chk("R1 boot word", v, boot_word(2'(m)));
            chk("R2 field decode", {pll_od, pll_f, pll_r}, {boot_word(2'(m))[25:23],
                boot_word(2'(m))[20:8], boot_word(2'(m))[6:0]});
        end

        // reset state with mode 11
        power_on(2'b11);
        chk("R3 no request after power-on", self_rst_req, 0);
        rd(8'd7, v); chk("R5 switch reset value", v, 0);
        rd(8'd8, v); chk("R6 reference reset value", v, 3);
        rd(8'd9, v); chk("R7 tile reset value", v, 0);
        get_period(1, p); chk("R5 switch period at reset", p, 1);
        get_period(2, p); chk("R6 reference period at reset", p, 4);
        get_period(0, p); chk("R7 tile period at reset", p, 1);

        // table of divider settings
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            wr(VECS[i].addr, VECS[i].data);
            chk("R8 divider write gives no request", self_rst_req, 0);
            get_period(int'(VECS[i].sel), p);
            get_period(int'(VECS[i].sel), p);
            chk($sformatf("R5/R6/R7 period vector %0d", i), p, VECS[i].per);
            chk("R7 bypass output", tile_bypass, VECS[i].byp);
            rd(8'd6, v); chk("R8 loop word untouched", v, boot_word(2'b11));
        end

        // R10: rewrite mid-period on reference divider (currently 6 -> period 7)
        wr(8'd8, 32'd3);
        get_period(2, p);
        while (!ref_en) @(negedge clk);
        wr(8'd8, 32'd0);
        p = 1;
        while (!ref_en && p < 100) begin @(negedge clk); p++; end
        chk("R10 old period completes", p, 4);
        @(negedge clk);
        chk("R10 new period applies next", ref_en, 1);

        // R11: unimplemented register
        wr(8'd7, 32'd5);
        wr(8'd5, 32'hFFFF_FFFF);
        chk("R11 no request on unused write", self_rst_req, 0);
        rd(8'd5, v);  chk("R11 unused reads zero", v, 0);
        rd(8'd10, v); chk("R11 unused reads zero (10)", v, 0);
        rd(8'd7, v);  chk("R11 neighbour unchanged", v, 5);
        rd(8'd6, v);  chk("R11 loop word unchanged", v, boot_word(2'b11));

        // R3 / R4 / R9 / R12: loop-word write and self-reset
        wr(8'd9, 32'h0001_0007);
        wr(8'd8, 32'd2);
        mode_pins = 2'b00;
        wr(8'd6, 32'h0100_5F00);
        chk("R3 request raised", self_rst_req, 1);
        chk("R2 example decode", {25'(pll_r), pll_f, pll_od}, {25'd0, 13'd95, 3'd2});
        wr(8'd7, 32'd9);
        chk("R9 enables low in window", {tile_en, sw_en, ref_en}, 0);
        wr(8'd6, 32'h0000_0123);
        c = 2;
        while (self_rst_req && c < 50) begin c++; @(negedge clk); end
        chk("R3 request length", c, 8);
        rd(8'd6, v); chk("R3 readback", v, 32'h0100_5F00);
        chk("R4 pins not reloaded", pll_f, 95);
        rd(8'd7, v); chk("R12 write in window ignored", v, 0);
        rd(8'd8, v); chk("R9 reference default", v, 3);
        rd(8'd9, v); chk("R9 tile default", v, 0);
        get_period(2, p); chk("R9 reference period after window", p, 4);

        // R4: power-on reload uses the changed pins
        power_on(2'b00);
        rd(8'd6, v); chk("R4 power-on reloads from pins", v, boot_word(2'b00));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule